// File: doc/BRIEF.md
# Two-Port Handshake Mailbox

This block joins two agents, called side A (host) and side B (guest). Each agent has its own synchronous register port. Each side owns four transmit words. The same four words appear, read-only, as the receive words of the other side. A sender fills its transmit words and then raises its valid flag. The receiver sees that flag as its receive-valid status, reads the words, and acknowledges.

The acknowledge is a coupled chain of flags. When the sender drops valid, the hardware clears the receiver's acknowledge one cycle later. The sender's view of that acknowledge falls with it, so the next message starts from a clean state. Each side has two interrupt outputs, each with its own enable. Each output gives a one-cycle pulse: one on a new incoming message, the other when the peer acknowledges. By convention, word 0 carries the message code, words 1 to 3 carry parameters, and word 2 can return an auxiliary value with a reply.

Word address map, the same on both sides (NW = 4 by default, and NW must be a power of two):

- Addresses 0 to NW-1: own transmit words.
- Addresses NW to 2NW-1: receive words.
- Address 2NW: control.
- Address 2NW+1: interrupt enables.

Top module: `mailbox_2port`

## Requirements
- R1: After reset, every readable location on both sides reads 0, and all four interrupt outputs are 0.
- R2: A write to address 0..3 updates that transmit word, byte lane by byte lane, under the byte enables. The side's own port reads it back at the same address.
- R3: The transmit word k of one side reads as address 4+k on the other side.
- R4: Control bit 0 (byte lane 0) is the side's own transmit-valid flag, which can be read and written. Control bit 8 reads the peer's transmit-valid flag as the receive-valid status.
- R5: A control write with byte lane 1 enabled and bit 9 set sets the side's acknowledge, if receive-valid is 1 in that cycle. The acknowledge reads back as bit 9 on that side and as bit 1 on the peer. The same write while receive-valid is 0 is ignored.
- R6: When a sender clears its valid flag, the receiver's acknowledge is cleared on the next clock edge. The sender's bit 1 then reads 0.
- R7: The valid interrupt (enable at address 9, bit 0) pulses for exactly one cycle after receive-valid rises. It stays low when the enable is 0.
- R8: The acknowledge interrupt (enable at address 9, bit 1) pulses for exactly one cycle after the control bit 1 indication rises. It stays low when the enable is 0.
- R9: Transmit-word writes while valid is set leave the valid and acknowledge flags unchanged. The peer reads the new data.
- R10: A control write with bit 9 = 0 does not clear an acknowledge. A control write without byte lane 0 does not change transmit-valid.
- R11: The two directions are independent. Each side's transmit words and flags feed only the other side's receive view.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_addr | input | AW | Side A word address |
| a_we | input | 1 | Side A write enable |
| a_be | input | DW/8 | Side A byte enables |
| a_wdata | input | DW | Side A write data |
| a_rdata | output | DW | Side A read data (combinational) |
| a_irq_valid | output | 1 | Side A new-message pulse |
| a_irq_ack | output | 1 | Side A acknowledge pulse |
| b_addr | input | AW | Side B word address |
| b_we | input | 1 | Side B write enable |
| b_be | input | DW/8 | Side B byte enables |
| b_wdata | input | DW | Side B write data |
| b_rdata | output | DW | Side B read data (combinational) |
| b_irq_valid | output | 1 | Side B new-message pulse |
| b_irq_ack | output | 1 | Side B acknowledge pulse |

## Verification
The hardest situation to catch is the one-cycle window in the clearing chain. The sender has already dropped valid, but its acknowledge indication still reads 1 for one cycle. The stimulus reaches it by clearing valid while the peer's acknowledge is held, then reading the sender's control word in the next half cycle, and again one cycle later. The interrupt pulses are sampled in the cycle right after the write that causes them and in the cycle after that. Each pulse source is also checked with its enable cleared.

// File: rtl/mailbox_2port.sv
module mailbox_2port #(
  parameter int DW = 32,
  parameter int NW = 4,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] a_addr,
  input  logic          a_we,
  input  logic [DW/8-1:0] a_be,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  output logic          a_irq_valid,
  output logic          a_irq_ack,
  input  logic [AW-1:0] b_addr,
  input  logic          b_we,
  input  logic [DW/8-1:0] b_be,
  input  logic [DW-1:0] b_wdata,
  output logic [DW-1:0] b_rdata,
  output logic          b_irq_valid,
  output logic          b_irq_ack
);
  localparam int BW  = DW / 8;
  localparam int WI  = $clog2(NW);
  localparam int CTL = 2 * NW;
  localparam int IEN = 2 * NW + 1;

  logic [AW-1:0] addr  [2];
  logic [BW-1:0] be    [2];
  logic [DW-1:0] wdata [2];
  logic [DW-1:0] rdata [2];
  logic [1:0]    we;

  logic [DW-1:0] tx_w [2][NW];
  logic [1:0] tx_vld, rx_ack, ien_v, ien_a, vld_d, ack_d;
  logic [1:0] dat_wr, ctl_wr, ien_wr, irq_v, irq_a;

  assign addr[0]  = a_addr;   assign addr[1]  = b_addr;
  assign be[0]    = a_be;     assign be[1]    = b_be;
  assign wdata[0] = a_wdata;  assign wdata[1] = b_wdata;
  assign we       = {b_we, a_we};

  always_comb begin
    for (int s = 0; s < 2; s++) begin
      dat_wr[s] = we[s] && (addr[s] < AW'(NW));
      ctl_wr[s] = we[s] && (addr[s] == AW'(CTL));
      ien_wr[s] = we[s] && (addr[s] == AW'(IEN));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < 2; s++)
        for (int w = 0; w < NW; w++)
          tx_w[s][w] <= '0;
      tx_vld <= '0;
      rx_ack <= '0;
      ien_v  <= '0;
      ien_a  <= '0;
      vld_d  <= '0;
      ack_d  <= '0;
    end else begin
      for (int s = 0; s < 2; s++) begin
        if (dat_wr[s])
          for (int b = 0; b < BW; b++)
            if (be[s][b])
              tx_w[s][addr[s][WI-1:0]][8*b +: 8] <= wdata[s][8*b +: 8];
        if (ctl_wr[s] && be[s][0])
          tx_vld[s] <= wdata[s][0];
        if (!tx_vld[1-s])
          rx_ack[s] <= 1'b0;
        else if (ctl_wr[s] && be[s][1] && wdata[s][9])
          rx_ack[s] <= 1'b1;
        if (ien_wr[s] && be[s][0]) begin
          ien_v[s] <= wdata[s][0];
          ien_a[s] <= wdata[s][1];
        end
        vld_d[s] <= tx_vld[1-s];
        ack_d[s] <= rx_ack[1-s];
      end
    end
  end

  always_comb begin
    for (int s = 0; s < 2; s++) begin
      rdata[s] = '0;
      if (addr[s] < AW'(NW))
        rdata[s] = tx_w[s][addr[s][WI-1:0]];
      else if (addr[s] < AW'(2 * NW))
        rdata[s] = tx_w[1-s][addr[s][WI-1:0]];
      else if (addr[s] == AW'(CTL)) begin
        rdata[s][0] = tx_vld[s];
        rdata[s][1] = rx_ack[1-s];
        rdata[s][8] = tx_vld[1-s];
        rdata[s][9] = rx_ack[s];
      end else if (addr[s] == AW'(IEN)) begin
        rdata[s][0] = ien_v[s];
        rdata[s][1] = ien_a[s];
      end
      irq_v[s] = ien_v[s] & tx_vld[1-s] & ~vld_d[s];
      irq_a[s] = ien_a[s] & rx_ack[1-s] & ~ack_d[s];
    end
  end

  assign a_rdata     = rdata[0];
  assign b_rdata     = rdata[1];
  assign a_irq_valid = irq_v[0];
  assign b_irq_valid = irq_v[1];
  assign a_irq_ack   = irq_a[0];
  assign b_irq_ack   = irq_a[1];
endmodule

// File: rtl/mailbox_2port_chk.sv
module mailbox_2port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] tx_vld,
  input logic [1:0] rx_ack,
  input logic       a_irq_ack,
  input logic       b_irq_valid
);
  // R6
  ack_clear_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_vld[0] |=> !rx_ack[1]);
  // R6
  ack_clear_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_vld[1] |=> !rx_ack[0]);
  // R5
  ack_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_ack[1]) |-> $past(tx_vld[0]));
  // R7
  irqv_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    b_irq_valid |=> !b_irq_valid);
  // R7
  irqv_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    b_irq_valid |-> tx_vld[0]);
  // R8
  irqa_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    a_irq_ack |=> !a_irq_ack);
  // R8
  irqa_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    a_irq_ack |-> rx_ack[1]);
endmodule

bind mailbox_2port mailbox_2port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tx_vld(tx_vld), .rx_ack(rx_ack),
  .a_irq_ack(a_irq_ack), .b_irq_valid(b_irq_valid)
);

// File: tb/tb_mailbox_2port.sv
module tb_mailbox_2port;
  logic clk = 0, rst_n = 0;
  logic [3:0] a_addr = 0, b_addr = 0;
  logic a_we = 0, b_we = 0;
  logic [3:0] a_be = 0, b_be = 0;
  logic [31:0] a_wdata = 0, b_wdata = 0;
  logic [31:0] a_rdata, b_rdata;
  logic a_irq_valid, a_irq_ack, b_irq_valid, b_irq_ack;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  mailbox_2port dut (.*);

  typedef struct packed {
    logic s; logic w; logic [3:0] a; logic [3:0] be; logic [31:0] d;
    logic cs; logic [3:0] ca; logic [31:0] e; logic [3:0] r;
  } vec_t;

  localparam vec_t VT [20] = '{
    '{0,1,0,4'hF,32'h11223344, 0,0,32'h11223344, 2}, // R2
    '{0,1,1,4'h3,32'hAABBCCDD, 0,1,32'h0000CCDD, 2}, // R2
    '{0,0,0,4'h0,32'h0,        1,4,32'h11223344, 3}, // R3
    '{0,0,0,4'h0,32'h0,        1,5,32'h0000CCDD, 3}, // R3
    '{0,1,2,4'hF,32'hCAFEF00D, 1,6,32'hCAFEF00D, 3}, // R3
    '{0,1,8,4'h1,32'h1,        0,8,32'h1,        4}, // R4
    '{0,0,0,4'h0,32'h0,        1,8,32'h100,      4}, // R4
    '{1,1,8,4'h2,32'h200,      1,8,32'h300,      5}, // R5
    '{0,0,0,4'h0,32'h0,        0,8,32'h3,        5}, // R5
    '{0,1,3,4'hF,32'h5,        0,8,32'h3,        9}, // R9
    '{0,0,0,4'h0,32'h0,        1,7,32'h5,        9}, // R9
    '{1,1,8,4'h2,32'h0,        1,8,32'h300,      10}, // R10
    '{0,1,8,4'h0,32'h0,        0,8,32'h3,        10}, // R10
    '{0,1,8,4'h1,32'h0,        0,8,32'h2,        6}, // R6
    '{0,0,0,4'h0,32'h0,        0,8,32'h0,        6}, // R6
    '{0,0,0,4'h0,32'h0,        1,8,32'h0,        6}, // R6
    '{1,1,8,4'h2,32'h200,      1,8,32'h0,        5}, // R5
    '{1,1,0,4'hF,32'h77,       0,4,32'h77,       11}, // R11
    '{0,0,0,4'h0,32'h0,        1,4,32'h11223344, 11}, // R11
    '{0,1,9,4'h1,32'h3,        0,9,32'h3,        7}  // R7
  };

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic s, input logic [3:0] ad, input logic [31:0] exp, input string req);
    if (s) b_addr = ad; else a_addr = ad;
    #2;
    check(s ? b_rdata : a_rdata, exp, req);
  endtask

  task automatic wr(input logic s, input logic [3:0] ad, input logic [3:0] bes, input logic [31:0] d);
    @(negedge clk);
    if (s) begin b_addr = ad; b_be = bes; b_wdata = d; b_we = 1; end
    else   begin a_addr = ad; a_be = bes; a_wdata = d; a_we = 1; end
    @(negedge clk);
    a_we = 0; b_we = 0;
  endtask

  task automatic irqs(input logic [3:0] exp, input string req);
    #2;
    check({28'b0, a_irq_valid, a_irq_ack, b_irq_valid, b_irq_ack}, {28'b0, exp}, req);
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    for (int ad = 0; ad < 10; ad++) begin
      rd(0, 4'(ad), 0, "R1");
      rd(1, 4'(ad), 0, "R1");
    end
    irqs(4'b0000, "R1");
    rst_n = 1;

    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (VT[i].w) begin
        if (VT[i].s) begin b_addr = VT[i].a; b_be = VT[i].be; b_wdata = VT[i].d; b_we = 1; end
        else         begin a_addr = VT[i].a; a_be = VT[i].be; a_wdata = VT[i].d; a_we = 1; end
      end
      @(negedge clk);
      a_we = 0; b_we = 0;
      rd(VT[i].cs, VT[i].ca, VT[i].e, $sformatf("R%0d", VT[i].r));
    end

    // R7 valid interrupt pulse, enabled on B
    wr(1, 9, 4'h1, 32'h1);
    wr(0, 8, 4'h1, 32'h1);
    irqs(4'b0010, "R7");
    @(negedge clk); irqs(4'b0000, "R7");
    // R8 ack interrupt pulse on A (enabled by table)
    wr(1, 8, 4'h2, 32'h200);
    irqs(4'b0100, "R8");
    @(negedge clk); irqs(4'b0000, "R8");
    // R7 disabled enable gives no pulse
    wr(0, 8, 4'h1, 32'h0);
    wr(1, 9, 4'h1, 32'h0);
    wr(0, 8, 4'h1, 32'h1);
    irqs(4'b0000, "R7");
    // R8 disabled enable gives no pulse
    wr(0, 9, 4'h1, 32'h1);
    wr(1, 8, 4'h2, 32'h200);
    irqs(4'b0000, "R8");
    rd(0, 8, 32'h103 & 32'h3, "R8");
    // R11 reverse direction valid interrupt on A
    wr(1, 8, 4'h1, 32'h1);
    irqs(4'b1000, "R11");
    rd(0, 8, 32'h103, "R11");

    // R1 reset again clears state
    @(negedge clk); rst_n = 0;
    rd(0, 0, 0, "R1");
    rd(1, 8, 0, "R1");
    rd(0, 9, 0, "R1");
    irqs(4'b0000, "R1");
    rst_n = 1;

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule